// File: doc/BRIEF.md
# Ring-Oscillator Pair Response Readout

This block turns a pair of free-running ring-oscillator lines into one response bit. A challenge names two oscillators, A and B, out of a parameterised array. The block counts the rising edges of each over the same window of system clock cycles and reports whether A's count reached B's. The oscillators are asynchronous to the system clock, so each selected line is synchronised before its edges are detected. The two counts are compared directly rather than divided.

The user sets `sel_a`, `sel_b`, `mask_en` and `window_len`, then pulses `start`. A rejected challenge raises `err` for one cycle instead. An accepted challenge holds `busy` through a short settling phase and the counting window, then pulses `done`. The response bit and both counts stay readable until the next accepted start. The counts are exposed for debug.

Top module: `ro_pair_readout`

## Requirements
- R1: `count_a` counts edges of oscillator `osc_in[sel_a]` and `count_b` counts edges of `osc_in[sel_b]`, using the indices sampled at the accepted start.
- R2: Each selected line passes through a two-flop synchroniser, and only its rising edges are counted. Counting happens only inside the measurement window. While `busy` is low both counts stay unchanged, even though the oscillators keep running.
- R3: When `done` is high, `resp` is 1 if `count_a` is greater than or equal to `count_b`, and 0 if `count_a` is smaller. Equal counts therefore give 1.
- R4: Each count is `CNT_W` bits wide and stops at all-ones (255 for 8 bits) instead of wrapping to zero.
- R5: An accepted start clears both counts during a three-cycle settling phase. Both counters are then enabled together for exactly `window_len` system clock cycles. A `window_len` of 0 yields two zero counts and a response of 1.
- R6: A `start` while `busy` is high is ignored: the running measurement keeps its pair and window, and no `err` results.
- R7: `done` is high for one cycle and `busy` is low in the following cycle. Every accepted start produces exactly one `done`. `resp` and both counts then hold until the next accepted start.
- R8: A start with `sel_a` equal to `sel_b` is rejected. `err` goes high for one cycle, in the cycle after the start. `busy` stays low and no `done` follows.
- R9: With `mask_en` at 1, oscillators form groups of `GROUP` consecutive indices (group = index / GROUP). A start whose two indices lie in different groups is rejected exactly as in R8. With `mask_en` at 0, any two distinct indices are accepted.
- R10: During reset, `busy`, `done` and `err` are 0 and both counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_in | input | NUM_OSC | Asynchronous ring-oscillator lines |
| sel_a | input | $clog2(NUM_OSC) | Index of oscillator A |
| sel_b | input | $clog2(NUM_OSC) | Index of oscillator B |
| mask_en | input | 1 | Restrict each pair to a single group |
| window_len | input | WIN_W | Window length in system clock cycles |
| start | input | 1 | One-cycle request to begin a measurement |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a rejected challenge |
| resp | output | 1 | Response bit: 1 when count A is at least count B |
| count_a | output | CNT_W | Edge count of oscillator A |
| count_b | output | CNT_W | Edge count of oscillator B |

## Verification
The bench builds the block with 16 oscillators, 8-bit counters, a 12-bit window and groups of eight. This gives two groups, so a cross-group challenge can be rejected under masking and accepted without it. The narrow counters let the fastest oscillators reach saturation within a 1500-cycle window. Two saturated counts give a tie, which exercises the rule that equal counts answer 1 even when A is the slower oscillator. The modelled oscillator periods run from 14 ns to 104 ns against the 4 ns system clock, so expected counts follow from the window length with a small phase tolerance.

// File: rtl/ro_puf_pkg.sv
// Shared definitions for the ring-oscillator pair readout.
// Assumes: synchroniser depth of at least two flops.
package ro_puf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2,
        ST_FINISH = 2'd3
    } meas_state_t;

    localparam int unsigned SYNC_DEPTH    = 2;
    // Synchroniser flops plus the edge-history flop must refill after a reselect.
    localparam int unsigned SETTLE_CYCLES = SYNC_DEPTH + 1;

endpackage

// File: rtl/ro_edge_counter.sv
// Synchronises one asynchronous oscillator line, detects its rising edges
// and counts them with saturation while enabled.
// Assumes: each high and low phase of the line lasts longer than one clock period.
module ro_edge_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             clear,
    input  logic             count_en,
    output logic [CNT_W-1:0] count
);
    import ro_puf_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [SYNC_DEPTH-1:0] sync_q;
    logic                  prev_q;
    logic                  rise;

    // Shift the asynchronous line into the clock domain and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_DEPTH-2:0], line_in};
            prev_q <= sync_q[SYNC_DEPTH-1];
        end
    end

    // A rising edge is a new high sample after a low one.
    always_comb rise = sync_q[SYNC_DEPTH-1] & ~prev_q;

    // Count edges inside the window, holding at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (count_en && rise && (count != CNT_MAX)) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ro_challenge_check.sv
// Decides whether a challenge pair is acceptable: the two indices must
// differ and, in masked mode, must fall in the same group.
// Assumes: GROUP is a power of two.
module ro_challenge_check #(
    parameter int NUM_OSC = 1024,
    parameter int GROUP   = 8,
    parameter int IDX_W   = $clog2(NUM_OSC)
) (
    input  logic [IDX_W-1:0] sel_a,
    input  logic [IDX_W-1:0] sel_b,
    input  logic             mask_en,
    output logic             accept
);
    localparam int GRP_SHIFT = $clog2(GROUP);

    logic same_group;

    generate
        if (GROUP <= 1) begin : g_single
            // Every oscillator is its own group.
            always_comb same_group = (sel_a == sel_b);
        end else if (GRP_SHIFT >= IDX_W) begin : g_whole
            // One group spans the whole array.
            always_comb same_group = 1'b1;
        end else begin : g_split
            // Group number is the index with its low bits dropped.
            always_comb same_group = (sel_a[IDX_W-1:GRP_SHIFT] == sel_b[IDX_W-1:GRP_SHIFT]);
        end
    endgenerate

    // Accept distinct pairs, restricted to one group when masking is on.
    always_comb accept = (sel_a != sel_b) && (!mask_en || same_group);

endmodule

// File: rtl/ro_seq_ctrl.sv
// Sequences one measurement: settle, count window, finish.
// Rejected challenges produce a one-cycle error pulse.
// Assumes: start is sampled only in the idle state.
module ro_seq_ctrl #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             accept,
    input  logic [WIN_W-1:0] window_len,
    output logic             load_sel,
    output logic             clear_cnt,
    output logic             count_en,
    output logic             busy,
    output logic             done,
    output logic             err
);
    import ro_puf_pkg::*;

    localparam int SET_W = $clog2(SETTLE_CYCLES + 1);

    meas_state_t      state;
    logic [WIN_W-1:0] timer;
    logic [SET_W-1:0] settle_cnt;
    logic             err_q;

    // Advance the measurement sequence and its cycle counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            timer      <= '0;
            settle_cnt <= '0;
            err_q      <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (accept) begin
                            state      <= ST_SETTLE;
                            timer      <= window_len;
                            settle_cnt <= '0;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (settle_cnt == SET_W'(SETTLE_CYCLES - 1)) begin
                        state <= (timer == '0) ? ST_FINISH : ST_RUN;
                    end else begin
                        settle_cnt <= settle_cnt + SET_W'(1);
                    end
                end
                ST_RUN: begin
                    timer <= timer - WIN_W'(1);
                    if (timer == WIN_W'(1)) begin
                        state <= ST_FINISH;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Decode control strobes from the current state.
    always_comb begin
        load_sel  = (state == ST_IDLE) && start && accept;
        clear_cnt = (state == ST_SETTLE);
        count_en  = (state == ST_RUN);
        busy      = (state != ST_IDLE);
        done      = (state == ST_FINISH);
        err       = err_q;
    end

endmodule

// File: rtl/ro_pair_readout.sv
// Top of the ring-oscillator pair readout: latches the challenge, routes
// the two chosen lines to their counters and forms the response bit.
// Assumes: oscillator lines are asynchronous and slower than half the clock rate.
module ro_pair_readout #(
    parameter int NUM_OSC = 1024,
    parameter int CNT_W   = 16,
    parameter int WIN_W   = 16,
    parameter int GROUP   = 8,
    localparam int IDX_W  = $clog2(NUM_OSC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OSC-1:0] osc_in,
    input  logic [IDX_W-1:0]   sel_a,
    input  logic [IDX_W-1:0]   sel_b,
    input  logic               mask_en,
    input  logic [WIN_W-1:0]   window_len,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               resp,
    output logic [CNT_W-1:0]   count_a,
    output logic [CNT_W-1:0]   count_b
);
    logic             accept;
    logic             load_sel;
    logic             clear_cnt;
    logic             count_en;
    logic [IDX_W-1:0] sel_a_q;
    logic [IDX_W-1:0] sel_b_q;
    logic             line_a;
    logic             line_b;

    ro_challenge_check #(
        .NUM_OSC(NUM_OSC),
        .GROUP  (GROUP),
        .IDX_W  (IDX_W)
    ) u_check (
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .mask_en(mask_en),
        .accept (accept)
    );

    ro_seq_ctrl #(
        .WIN_W(WIN_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .accept    (accept),
        .window_len(window_len),
        .load_sel  (load_sel),
        .clear_cnt (clear_cnt),
        .count_en  (count_en),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    // Capture the accepted challenge for the whole measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_a_q <= '0;
            sel_b_q <= '0;
        end else if (load_sel) begin
            sel_a_q <= sel_a;
            sel_b_q <= sel_b;
        end
    end

    // Route the two chosen oscillator lines.
    always_comb begin
        line_a = osc_in[sel_a_q];
        line_b = osc_in[sel_b_q];
    end

    ro_edge_counter #(.CNT_W(CNT_W)) u_cnt_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_a),
        .clear   (clear_cnt),
        .count_en(count_en),
        .count   (count_a)
    );

    ro_edge_counter #(.CNT_W(CNT_W)) u_cnt_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_b),
        .clear   (clear_cnt),
        .count_en(count_en),
        .count   (count_b)
    );

    // One-bit magnitude comparison in place of a ratio.
    always_comb resp = (count_a >= count_b);

endmodule

// File: rtl/ro_pair_readout_chk.sv
// Property checker for ro_pair_readout, attached by bind.
module ro_pair_readout_chk #(
    parameter int NUM_OSC = 1024,
    parameter int CNT_W   = 16,
    parameter int GROUP   = 8,
    parameter int IDX_W   = $clog2(NUM_OSC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             mask_en,
    input logic [IDX_W-1:0] sel_a,
    input logic [IDX_W-1:0] sel_b,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [CNT_W-1:0] count_a,
    input logic [CNT_W-1:0] count_b,
    input logic [IDX_W-1:0] sel_a_q,
    input logic [IDX_W-1:0] sel_b_q
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic grp_diff;
    always_comb grp_diff = ((int'(sel_a) / GROUP) != (int'(sel_b) / GROUP));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(count_a) && $stable(count_b)));

    assert_no_wrap_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && count_a == CMAX) |=> (count_a == CMAX || count_a == '0));

    assert_no_wrap_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && count_b == CMAX) |=> (count_b == CMAX || count_b == '0));

    assert_busy_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(sel_a_q) && $stable(sel_b_q)));

    assert_busy_start_no_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !err);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_same_sel_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && sel_a == sel_b) |=> (err && !busy));

    assert_err_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !done);

    assert_group_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mask_en && grp_diff) |=> (err && !busy));

endmodule

bind ro_pair_readout ro_pair_readout_chk #(
    .NUM_OSC(NUM_OSC),
    .CNT_W  (CNT_W),
    .GROUP  (GROUP),
    .IDX_W  (IDX_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mask_en(mask_en),
    .sel_a  (sel_a),
    .sel_b  (sel_b),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .count_a(count_a),
    .count_b(count_b),
    .sel_a_q(sel_a_q),
    .sel_b_q(sel_b_q)
);

// File: tb/sim_ro_pair_readout.sv
`timescale 1ns/1ps
module sim_ro_pair_readout;
    localparam int NOSC = 16;
    localparam int CW   = 8;
    localparam int WW   = 12;
    localparam int GRP  = 8;
    localparam int IW   = 4;
    localparam int CMAX = 255;

    logic            clk;
    logic            rst_n;
    wire  [NOSC-1:0] osc;
    logic [IW-1:0]   sel_a;
    logic [IW-1:0]   sel_b;
    logic            mask_en;
    logic [WW-1:0]   window_len;
    logic            start;
    logic            busy;
    logic            done;
    logic            err;
    logic            resp;
    logic [CW-1:0]   count_a;
    logic [CW-1:0]   count_b;

    ro_pair_readout #(
        .NUM_OSC(NOSC),
        .CNT_W  (CW),
        .WIN_W  (WW),
        .GROUP  (GRP)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_in    (osc),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .mask_en   (mask_en),
        .window_len(window_len),
        .start     (start),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .resp      (resp),
        .count_a   (count_a),
        .count_b   (count_b)
    );

    // 250 MHz system clock.
    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Oscillator i has a period of 14 + 6*i ns with its own phase.
    for (genvar gi = 0; gi < NOSC; gi++) begin : g_osc
        logic o;
        initial begin
            o = 1'b0;
            #(1.0 + 0.3 * gi);
            forever #(7.0 + 3.0 * gi) o = ~o;
        end
        assign osc[gi] = o;
    end

    typedef struct {
        bit    is_err;
        bit    resp;
        int    ea;
        int    eb;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t got;
    int   n_tests  = 0;
    int   n_fail   = 0;
    bit   prev_done = 1'b0;
    bit   finished  = 1'b0;

    function automatic int exp_cnt(int idx, int win);
        int e;
        e = (win * 4) / (14 + 6 * idx);
        if (e > CMAX) e = CMAX;
        return e;
    endfunction

    function automatic bit close_to(int act, int expv);
        if (expv == CMAX) return act == CMAX;
        return (act - expv <= 2) && (expv - act <= 2);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: pop one expectation for every done or err pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) check(1'b0, "R7", "done wider than one cycle", 1, 0);
            prev_done = done;
            if (done || err) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7", "completion with nothing expected", int'(done), 0);
                end else begin
                    got = sb_q.pop_front();
                    if (got.is_err) begin
                        check(err && !done, got.tag, "rejection pulse", int'(err), 1);
                    end else begin
                        check(done && !err, got.tag, "done pulse", int'(done), 1);
                        check(resp == got.resp, got.tag, "resp", int'(resp), int'(got.resp));
                        check(close_to(int'(count_a), got.ea), got.tag, "count_a", int'(count_a), got.ea);
                        check(close_to(int'(count_b), got.eb), got.tag, "count_b", int'(count_b), got.eb);
                    end
                end
            end
        end
    end

    // Driver: push the expected outcome, then issue the challenge.
    task automatic measure(int a, int b, bit m, int win, bit rej, string tag);
        exp_t e;
        e.is_err = rej;
        e.ea     = rej ? 0 : exp_cnt(a, win);
        e.eb     = rej ? 0 : exp_cnt(b, win);
        e.resp   = (e.ea >= e.eb);
        e.tag    = tag;
        sb_q.push_back(e);
        @(negedge clk);
        sel_a      = IW'(a);
        sel_b      = IW'(b);
        mask_en    = m;
        window_len = WW'(win);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (rej) begin
            check(!busy, tag, "busy after rejected start", int'(busy), 0);
            repeat (2) @(negedge clk);
        end else begin
            check(busy, tag, "busy after accepted start", int'(busy), 1);
            while (busy) @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        logic [CW-1:0] ha;
        logic [CW-1:0] hb;
        logic          hr;
        rst_n      = 1'b0;
        start      = 1'b0;
        sel_a      = '0;
        sel_b      = '0;
        mask_en    = 1'b0;
        window_len = '0;
        repeat (5) @(negedge clk);
        // R10: reset state
        check(!busy && !done && !err, "R10", "flags in reset", int'({busy, done, err}), 0);
        check(count_a == 0 && count_b == 0, "R10", "counts in reset", int'(count_a) + int'(count_b), 0);
        rst_n = 1'b1;
        @(negedge clk);

        measure(2, 5, 1'b0, 400, 1'b0, "R1");
        measure(6, 1, 1'b0, 400, 1'b0, "R3");

        // R7 and R2: results hold while idle with oscillators running.
        ha = count_a; hb = count_b; hr = resp;
        repeat (30) @(negedge clk);
        check(count_a == ha && count_b == hb, "R2", "counts drift while idle", int'(count_a), int'(ha));
        check(resp == hr, "R7", "resp held after done", int'(resp), int'(hr));

        // R4: both saturate; equal counts answer 1 even with A slower.
        measure(0, 1, 1'b0, 1500, 1'b0, "R4");
        measure(1, 0, 1'b0, 1500, 1'b0, "R4");
        check(count_a == CW'(CMAX), "R4", "saturated count_a", int'(count_a), CMAX);

        measure(3, 4, 1'b0, 0, 1'b0, "R5");
        measure(4, 3, 1'b0, 200, 1'b0, "R5");

        measure(7, 7, 1'b0, 100, 1'b1, "R8");

        measure(3, 12, 1'b1, 400, 1'b1, "R9");
        measure(9, 14, 1'b1, 300, 1'b0, "R9");
        measure(3, 12, 1'b0, 400, 1'b0, "R9");

        // R6: a second start during the run must not change anything.
        begin
            exp_t e;
            e.is_err = 1'b0;
            e.ea     = exp_cnt(6, 400);
            e.eb     = exp_cnt(1, 400);
            e.resp   = (e.ea >= e.eb);
            e.tag    = "R6";
            sb_q.push_back(e);
        end
        @(negedge clk);
        sel_a = IW'(6); sel_b = IW'(1); mask_en = 1'b0; window_len = WW'(400); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        sel_a = IW'(1); sel_b = IW'(6); window_len = WW'(50); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !err, "R6", "busy kept, no err after ignored start", int'(busy), 1);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);

        check(sb_q.size() == 0, "R7", "outstanding expected completions", sb_q.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

endmodule